// File: doc/BRIEF.md
# Pixel Stream Transmitter with Idle Insertion

This block serializes pixel data onto a one-bit link. Each 32-bit word read from a first-word-fall-through transmit FIFO carries two 16-bit pixels. A frame opens with a programmable SYNC word, followed by a programmable number of lines. Each line holds a programmable number of pixel pairs. Every 16-bit unit on the link is sent MSB first, one bit per `clk_i` cycle. The link clock is `clk_i` itself, forwarded outside the block.

A programmable IDLE word is sent after every line, so it sits between lines and also closes each frame. When the idle-enable control is set, IDLE words also fill all other time while the transmitter is enabled. When idle-enable is clear, the output is undriven outside a frame.

Once a frame has started, the block may need a FIFO word while the FIFO is empty. In that case it raises a sticky underflow flag, drops the frame and falls back to IDLE or to undriven output. It starts no new frame until software clears the flag. The flag can be routed to an interrupt output.

Top module: `pix_link_tx`

## Requirements
- R1: Each 16-bit unit occupies exactly 16 consecutive cycles with `ser_oe_o` high, MSB first. `word_start_o` is high only in the cycle of its first bit.
- R2: A frame is sent in this order:
  - the SYNC word;
  - for each of `lines_per_frame_i` lines, `words_per_line_i` FIFO words (two pixels each), then one IDLE word after every line, including the last.
  - A count of 0 in either length input acts as 1.
- R3: With `order_i`=0, bits 15:0 of a FIFO word go out before bits 31:16. With `order_i`=1, bits 31:16 go first.
- R4: A frame starts only at a unit boundary, and only when `en_i`=1, the FIFO is non-empty and the underflow flag is clear. `fifo_rd_o` pulses once per consumed word and never while `fifo_empty_i`=1.
- R5: With `idle_en_i`=1 and `en_i`=1, every unit sent outside a frame is the IDLE word.
- R6: With `idle_en_i`=0, `ser_oe_o`, `ser_d_o` and `word_start_o` stay 0 outside a frame.
- R7: If the FIFO is empty when a pixel word is needed inside a frame:
  - `uf_o` rises;
  - the next unit is IDLE (or undriven, if `idle_en_i`=0);
  - no FIFO read happens while `uf_o`=1.
- R8: `uf_o` holds until a cycle with `uf_clr_i`=1. If an underflow and a clear fall in the same cycle, the underflow wins.
- R9: `irq_o` is high exactly when `uf_o`=1 and `irq_en_i`=1.
- R10: Dropping `en_i` ends output at the next unit boundary without raising `uf_o`. The next enable starts a fresh frame with SYNC.
- R11: During reset, `ser_oe_o`, `ser_d_o`, `word_start_o`, `fifo_rd_o`, `uf_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmitter enable |
| idle_en_i | input | 1 | Fill all non-frame time with IDLE |
| order_i | input | 1 | 0: low pixel first, 1: high pixel first |
| irq_en_i | input | 1 | Route underflow to interrupt |
| uf_clr_i | input | 1 | Write-one-to-clear for the underflow flag |
| idle_pat_i | input | 16 | IDLE word value |
| sync_pat_i | input | 16 | SYNC word value |
| words_per_line_i | input | 8 | FIFO words (pixel pairs) per line |
| lines_per_frame_i | input | 8 | Lines per frame |
| fifo_empty_i | input | 1 | Transmit FIFO empty |
| fifo_data_i | input | 32 | Transmit FIFO head word |
| fifo_rd_o | output | 1 | Pop the FIFO head |
| ser_d_o | output | 1 | Serial data |
| ser_oe_o | output | 1 | Serial output driven |
| word_start_o | output | 1 | First bit of a 16-bit unit |
| uf_o | output | 1 | Sticky underflow flag |
| irq_o | output | 1 | Underflow interrupt |

## Verification
Underflow detection and the write-one-to-clear of its flag can land on the same clock edge. The bench provokes this by holding `uf_clr_i` high for the whole of a frame that starves after one word. Because the set must win and the clear then takes effect on the following edge, `uf_o` must be seen high in exactly one sampled cycle. A separate check covers data arriving while the flag is set: it must not be read and must not start a frame.

// File: rtl/pix_link_pkg.sv
package pix_link_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_IDLE,
    ST_SYNC,
    ST_PIXA,
    ST_PIXB,
    ST_LGAP,
    ST_FGAP
  } tx_st_e;
endpackage

// File: rtl/ptx_shifter.sv
module ptx_shifter #(
  parameter int PIX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PIX_W-1:0] word_i,
  output logic             bit_o,
  output logic             first_o,
  output logic             last_o
);
  localparam int CW = (PIX_W > 1) ? $clog2(PIX_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(PIX_W - 1);

  logic [PIX_W-1:0] sh_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= word_i;
      cnt_q <= '0;
    end else begin
      sh_q  <= {sh_q[PIX_W-2:0], 1'b0};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_o   = sh_q[PIX_W-1];
  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == LAST);
endmodule

// File: rtl/ptx_seq.sv
module ptx_seq
  import pix_link_pkg::*;
#(
  parameter int PIX_W = 16,
  parameter int CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               en_i,
  input  logic               idle_en_i,
  input  logic               order_i,
  input  logic               uf_i,
  input  logic [PIX_W-1:0]   sync_pat_i,
  input  logic [PIX_W-1:0]   idle_pat_i,
  input  logic [CNT_W-1:0]   wpl_i,
  input  logic [CNT_W-1:0]   lpf_i,
  input  logic               fifo_empty_i,
  input  logic [2*PIX_W-1:0] fifo_data_i,
  output logic               fifo_rd_o,
  output logic               uf_set_o,
  output tx_st_e             st_o,
  output logic [PIX_W-1:0]   word_o
);
  localparam int WORD_W = 2 * PIX_W;

  tx_st_e           st_q, st_d;
  logic [PIX_W-1:0] hold_q, hold_d;
  logic [CNT_W-1:0] wc_q, wc_d, lc_q, lc_d;
  logic [CNT_W:0]   wc_inc, lc_inc;
  logic             last_word, last_line, do_fetch;
  logic [PIX_W-1:0] pix_lo, pix_hi;
  tx_st_e           rest_st;

  assign pix_lo    = fifo_data_i[PIX_W-1:0];
  assign pix_hi    = fifo_data_i[WORD_W-1:PIX_W];
  assign wc_inc    = {1'b0, wc_q} + (CNT_W+1)'(1);
  assign lc_inc    = {1'b0, lc_q} + (CNT_W+1)'(1);
  // a zero length acts as one
  assign last_word = (wc_inc >= {1'b0, wpl_i});
  assign last_line = (lc_inc >= {1'b0, lpf_i});
  assign rest_st   = idle_en_i ? ST_IDLE : ST_OFF;

  always_comb begin
    st_d      = st_q;
    hold_d    = hold_q;
    wc_d      = wc_q;
    lc_d      = lc_q;
    word_o    = idle_pat_i;
    fifo_rd_o = 1'b0;
    uf_set_o  = 1'b0;
    do_fetch  = 1'b0;
    if (load_i) begin
      if (!en_i) begin
        st_d = ST_OFF;
        wc_d = '0;
        lc_d = '0;
      end else begin
        unique case (st_q)
          ST_OFF, ST_IDLE, ST_FGAP: begin
            wc_d = '0;
            lc_d = '0;
            if (!uf_i && !fifo_empty_i) begin
              st_d   = ST_SYNC;
              word_o = sync_pat_i;
            end else begin
              st_d = rest_st;
            end
          end
          ST_SYNC, ST_LGAP: do_fetch = 1'b1;
          ST_PIXA: begin
            st_d   = ST_PIXB;
            word_o = hold_q;
          end
          ST_PIXB: begin
            if (last_word) begin
              wc_d = '0;
              if (last_line) begin
                lc_d = '0;
                st_d = ST_FGAP;
              end else begin
                lc_d = lc_inc[CNT_W-1:0];
                st_d = ST_LGAP;
              end
            end else begin
              wc_d     = wc_inc[CNT_W-1:0];
              do_fetch = 1'b1;
            end
          end
          default: st_d = ST_OFF;
        endcase
        if (do_fetch) begin
          if (!fifo_empty_i) begin
            fifo_rd_o = 1'b1;
            st_d      = ST_PIXA;
            word_o    = order_i ? pix_hi : pix_lo;
            hold_d    = order_i ? pix_lo : pix_hi;
          end else begin
            uf_set_o = 1'b1;
            st_d     = rest_st;
            wc_d     = '0;
            lc_d     = '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      hold_q <= '0;
      wc_q   <= '0;
      lc_q   <= '0;
    end else if (load_i) begin
      st_q   <= st_d;
      hold_q <= hold_d;
      wc_q   <= wc_d;
      lc_q   <= lc_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/ptx_uf_flag.sv
module ptx_uf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic uf_o,
  output logic irq_o
);
  logic uf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     uf_q <= 1'b0;
    else if (set_i)  uf_q <= 1'b1;  // set beats clear
    else if (clr_i)  uf_q <= 1'b0;
  end

  assign uf_o  = uf_q;
  assign irq_o = uf_q & irq_en_i;
endmodule

// File: rtl/pix_link_tx.sv
module pix_link_tx
  import pix_link_pkg::*;
#(
  parameter int PIX_W = 16,
  parameter int CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               idle_en_i,
  input  logic               order_i,
  input  logic               irq_en_i,
  input  logic               uf_clr_i,
  input  logic [PIX_W-1:0]   idle_pat_i,
  input  logic [PIX_W-1:0]   sync_pat_i,
  input  logic [CNT_W-1:0]   words_per_line_i,
  input  logic [CNT_W-1:0]   lines_per_frame_i,
  input  logic               fifo_empty_i,
  input  logic [2*PIX_W-1:0] fifo_data_i,
  output logic               fifo_rd_o,
  output logic               ser_d_o,
  output logic               ser_oe_o,
  output logic               word_start_o,
  output logic               uf_o,
  output logic               irq_o
);
  tx_st_e           st;
  logic             load, bit_out, first, last, uf_set;
  logic [PIX_W-1:0] next_word;

  assign load = (st == ST_OFF) || last;

  ptx_seq #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .en_i         (en_i),
    .idle_en_i    (idle_en_i),
    .order_i      (order_i),
    .uf_i         (uf_o),
    .sync_pat_i   (sync_pat_i),
    .idle_pat_i   (idle_pat_i),
    .wpl_i        (words_per_line_i),
    .lpf_i        (lines_per_frame_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_data_i  (fifo_data_i),
    .fifo_rd_o    (fifo_rd_o),
    .uf_set_o     (uf_set),
    .st_o         (st),
    .word_o       (next_word)
  );

  ptx_shifter #(.PIX_W(PIX_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .word_i  (next_word),
    .bit_o   (bit_out),
    .first_o (first),
    .last_o  (last)
  );

  ptx_uf_flag u_uf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (uf_set),
    .clr_i    (uf_clr_i),
    .irq_en_i (irq_en_i),
    .uf_o     (uf_o),
    .irq_o    (irq_o)
  );

  assign ser_oe_o     = (st != ST_OFF);
  assign ser_d_o      = ser_oe_o & bit_out;
  assign word_start_o = ser_oe_o & first;
endmodule

// File: rtl/pix_link_tx_chk.sv
module pix_link_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic irq_en_i,
  input logic uf_clr_i,
  input logic fifo_empty_i,
  input logic fifo_rd_o,
  input logic ser_d_o,
  input logic ser_oe_o,
  input logic word_start_o,
  input logic uf_o,
  input logic irq_o
);
  p_start_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_start_o |=> !word_start_o);
  p_rd_nonempty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> !fifo_empty_i);
  p_quiet_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_oe_o |-> (!ser_d_o && !word_start_o));
  p_uf_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uf_o) |-> $past(fifo_empty_i));
  p_uf_noread_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |-> !fifo_rd_o);
  p_uf_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_o && !uf_clr_i) |=> uf_o);
  p_irq_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> uf_o);
  p_off_stays_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ser_oe_o) |=> !ser_oe_o);
endmodule

bind pix_link_tx pix_link_tx_chk u_chk (.*);

// File: tb/tb_pix_link_tx.sv
`timescale 1ns/1ps
module tb_pix_link_tx;
  localparam logic [15:0] IDLE = 16'h5A3C;
  localparam logic [15:0] SYNC = 16'hF00F;
  // {wpl[3:0], lpf[3:0], order, idle_en}
  localparam int NV = 5;
  localparam logic [9:0] VEC [0:NV-1] = '{
    {4'd2, 4'd2, 1'b0, 1'b0},
    {4'd1, 4'd3, 1'b1, 1'b1},
    {4'd3, 4'd1, 1'b0, 1'b1},
    {4'd2, 4'd1, 1'b1, 1'b0},
    {4'd0, 4'd2, 1'b0, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic en = 0, idle_en = 0, order = 0, irq_en = 0, uf_clr = 0;
  logic [7:0] wpl = 8'd1, lpf = 8'd1;
  logic fifo_empty, fifo_rd, ser_d, ser_oe, word_start, uf, irq;
  logic [31:0] fifo_data;
  logic [31:0] mem [0:255];
  logic [7:0] rd_ptr, wr_ptr = 0;
  int checks = 0, fails = 0, ncap = 0, nbit = 0, fmt_err = 0;
  logic [15:0] acc;
  logic [15:0] cap [0:1023];
  logic [15:0] expw [0:63];
  bit done = 0;

  always #2.5 clk = ~clk;

  pix_link_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .idle_en_i(idle_en), .order_i(order),
    .irq_en_i(irq_en), .uf_clr_i(uf_clr), .idle_pat_i(IDLE), .sync_pat_i(SYNC),
    .words_per_line_i(wpl), .lines_per_frame_i(lpf), .fifo_empty_i(fifo_empty),
    .fifo_data_i(fifo_data), .fifo_rd_o(fifo_rd), .ser_d_o(ser_d), .ser_oe_o(ser_oe),
    .word_start_o(word_start), .uf_o(uf), .irq_o(irq));

  assign fifo_empty = (rd_ptr == wr_ptr);
  assign fifo_data  = mem[rd_ptr];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_ptr <= '0;
    else if (fifo_rd) rd_ptr <= rd_ptr + 8'd1;

  // deserializer: rebuilds 16-bit units, flags framing errors (R1)
  always @(negedge clk) begin
    if (ser_oe && word_start) begin
      if (nbit != 0) fmt_err++;
      acc = {15'b0, ser_d};
      nbit = 1;
    end else if (ser_oe && nbit > 0) begin
      acc = {acc[14:0], ser_d};
      nbit++;
    end else if (!ser_oe && nbit != 0) begin
      fmt_err++;
      nbit = 0;
    end
    if (nbit == 16) begin
      cap[ncap % 1024] = acc;
      ncap++;
      nbit = 0;
    end
  end

  function automatic logic [31:0] mkw(int v, int j);
    return {4'(v + 1), 12'(2 * j + 1), 4'(v + 1), 12'(2 * j)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic push(int v, int j);
    mem[wr_ptr] = mkw(v, j);
    wr_ptr = wr_ptr + 8'd1;
  endtask

  task automatic build_exp(int v, int w, int l, bit ord, output int n);
    int j = 0;
    logic [31:0] d;
    n = 0;
    expw[n++] = SYNC;
    for (int li = 0; li < l; li++) begin
      for (int wi = 0; wi < w; wi++) begin
        d = mkw(v, j++);
        expw[n++] = ord ? d[31:16] : d[15:0];
        expw[n++] = ord ? d[15:0] : d[31:16];
      end
      expw[n++] = IDLE;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base, n, bad, cnt;
    logic [7:0] rp;
    cyc(3);
    // R11 reset state
    chk(!ser_oe && !ser_d && !word_start, "R11", "link quiet in reset", {ser_oe, ser_d, word_start}, 0);
    chk(!fifo_rd && !uf && !irq, "R11", "rd/uf/irq low in reset", {fifo_rd, uf, irq}, 0);
    rst_n = 1;
    cyc(4);

    // table of frame vectors: R2, R3, R4, R5, R6
    for (int v = 0; v < NV; v++) begin
      int w, l;
      en = 0;
      cyc(40);
      w = int'(VEC[v][9:6]);
      l = int'(VEC[v][5:2]);
      order = VEC[v][1];
      idle_en = VEC[v][0];
      wpl = 8'(w);
      lpf = 8'(l);
      if (w == 0) w = 1;
      for (int j = 0; j < w * l; j++) push(v, j);
      build_exp(v, w, l, order, n);
      base = ncap;
      en = 1;
      cyc((n + 2) * 16);
      bad = -1;
      for (int i = 0; i < n; i++)
        if (bad < 0 && cap[(base + i) % 1024] !== expw[i]) bad = i;
      chk(bad < 0 && ncap >= base + n, "R2", $sformatf("frame vec%0d (R3 order=%0b)", v, order),
          (bad < 0) ? 32'(ncap - base) : 32'(cap[(base + bad) % 1024]),
          (bad < 0) ? 32'(n) : 32'(expw[bad]));
      chk(rd_ptr == wr_ptr, "R4", $sformatf("all words consumed vec%0d", v), rd_ptr, wr_ptr);
      if (idle_en)
        chk(ncap > base + n && cap[(base + n) % 1024] == IDLE, "R5",
            $sformatf("idle after frame vec%0d", v), cap[(base + n) % 1024], IDLE);
      else
        chk(!ser_oe && ncap == base + n, "R6", $sformatf("quiet after frame vec%0d", v),
            32'(ncap - base), 32'(n));
      chk(!uf, "R7", $sformatf("no underflow on clean frame vec%0d", v), uf, 0);
    end

    // R5: idle stream with empty FIFO
    en = 0; cyc(40);
    idle_en = 1; base = ncap; en = 1;
    cyc(80);
    bad = 0;
    for (int i = 0; i < 4; i++) if (cap[(base + i) % 1024] != IDLE) bad++;
    chk(ncap >= base + 4 && bad == 0 && !uf, "R5", "continuous idle while enabled", 32'(bad), 0);

    // R6: no idle fill, empty FIFO
    en = 0; cyc(40);
    idle_en = 0; en = 1;
    cnt = 0;
    for (int i = 0; i < 60; i++) begin cyc(1); if (ser_oe) cnt++; end
    chk(cnt == 0, "R6", "undriven with idle fill off", cnt, 0);

    // R7/R9: underflow on the 4th fetch of a 2x2 frame
    en = 0; cyc(40);
    wpl = 8'd2; lpf = 8'd2; order = 0; idle_en = 1; irq_en = 0;
    for (int j = 0; j < 3; j++) push(8, j);
    build_exp(8, 2, 2, 0, n);
    expw[8] = IDLE;
    base = ncap; en = 1;
    cyc(20 * 16);
    bad = -1;
    for (int i = 0; i < 9; i++)
      if (bad < 0 && cap[(base + i) % 1024] !== expw[i]) bad = i;
    chk(bad < 0, "R7", "stream up to underflow then idle",
        (bad < 0) ? 0 : 32'(cap[(base + bad) % 1024]), (bad < 0) ? 0 : 32'(expw[bad]));
    chk(uf && !irq, "R9", "flag set, interrupt masked", {uf, irq}, 2'b10);
    irq_en = 1; #1;
    chk(irq, "R9", "interrupt with enable", irq, 1);
    push(9, 0);
    rp = rd_ptr; base = ncap;
    cyc(64);
    chk(rd_ptr == rp && !fifo_empty, "R7", "no read while flag set", rd_ptr, rp);
    chk(cap[base % 1024] == IDLE && cap[(base + 2) % 1024] == IDLE, "R7", "no frame while flag set",
        cap[(base + 2) % 1024], IDLE);
    chk(uf, "R8", "flag sticky", uf, 1);
    base = ncap;
    uf_clr = 1; cyc(1); uf_clr = 0;
    chk(!uf && !irq, "R8", "clear drops flag", {uf, irq}, 0);
    cyc(40);
    chk(cap[base % 1024] == SYNC || cap[(base + 1) % 1024] == SYNC, "R8", "frame restarts after clear",
        cap[(base + 1) % 1024], SYNC);
    cyc(80);
    chk(uf, "R7", "second starved frame sets flag", uf, 1);

    // R8: set and clear in the same cycle
    en = 0; cyc(40);
    uf_clr = 1; cyc(2);
    push(10, 0);
    en = 1;
    cnt = 0;
    for (int i = 0; i < 120; i++) begin cyc(1); if (uf) cnt++; end
    uf_clr = 0;
    chk(cnt == 1, "R8", "set wins over simultaneous clear", cnt, 1);

    // R10: disable mid-frame
    en = 0; cyc(40);
    irq_en = 0; idle_en = 0; wpl = 8'd4; lpf = 8'd2;
    for (int j = 0; j < 8; j++) push(11, j);
    base = ncap; en = 1;
    cyc(40);
    en = 0;
    cyc(20);
    chk(!ser_oe && !uf, "R10", "disable ends output without underflow", {ser_oe, uf}, 0);
    chk(cap[base % 1024] == SYNC, "R10", "aborted frame began with sync", cap[base % 1024], SYNC);
    base = ncap; en = 1;
    cyc(20);
    chk(ncap > base && cap[base % 1024] == SYNC, "R10", "re-enable starts with sync", cap[base % 1024], SYNC);
    en = 0; cyc(40);
    chk(fmt_err == 0, "R1", "16-cycle MSB-first unit framing", fmt_err, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule